// File: doc/BRIEF.md
# Parallel Read Response Comparator

This block sits on the response side of a memory test engine. A start pulse opens a sequence of SLOTS capture windows. The first window takes the read data in the same clock edge that samples the start pulse. Each later window follows the previous one by a programmable access time counted in clock cycles. Every window loads its own capture register. When the last word is in, each capture register is compared with its own reference word.

Before the mismatches are reported, bit positions selected by a loadable mask register are removed. The result is a per-slot fail vector and a one-cycle done pulse. A sticky fail flag gathers failures across sequences until it is cleared. The engine that produces the reference words and drives the memory is outside this block.

Top module: `rsp_compare`

## Requirements
- R1: After reset, cap_stb_o, busy_o, done_o, fail_vec_o and sticky_o are all zero, and the mask register holds zero.
- R2: A start accepted at clock edge E0 strobes slot i (cap_stb_o bit i) in the cycle that ends at edge E0 + i*T, and at no other time. T is acc_time_i sampled at E0. rd_data_i is stored into slot i only at that edge.
- R3: An acc_time_i value of 0 is treated as an access time of 1 cycle.
- R4: fail_vec_o bit i equals the OR over all bits of ((capture_i XOR ref_i word i) AND NOT mask). Word i is ref_i[i*DW +: DW], and a mask bit set to 1 excludes that bit position.
- R5: The mask register loads mask_d_i only on a clock edge with mask_we_i high. Changes to mask_d_i without mask_we_i have no effect.
- R6: done_o is high for exactly the one cycle after the edge that follows the last capture. fail_vec_o changes only when done_o rises and holds between sequences. ref_i and the mask are used at that edge.
- R7: sticky_o is set by a done with any fail bit high. It holds until a clock edge with clr_i high clears it. If a clear and a failing done fall on the same edge, the set wins.
- R8: A start pulse while busy_o is high is ignored: the strobe timing of the running sequence does not change.
- R9: busy_o rises at the edge that accepts a start and falls at the edge of the last capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a capture sequence (ignored while busy) |
| acc_time_i | input | TW | Access time in cycles between strobes (0 means 1) |
| mask_we_i | input | 1 | Load enable for the mask register |
| mask_d_i | input | DW | New mask value; a 1 excludes that bit |
| rd_data_i | input | DW | Read data from the memory under test |
| ref_i | input | SLOTS*DW | Reference words, slot i at bits i*DW +: DW |
| clr_i | input | 1 | Clear the sticky fail flag |
| cap_stb_o | output | SLOTS | Capture strobe per slot |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle result pulse |
| fail_vec_o | output | SLOTS | Per-slot fail result, held until the next done |
| sticky_o | output | 1 | Accumulated fail flag |

## Verification
Clearing the sticky flag and a failing result can land on the same clock edge. The bench raises clr_i in the cycle before done_o for a run with a failing slot, then checks that sticky_o ends up set. The same clear paired with a passing run must leave the flag low. A second start arriving while busy_o is high can also coincide with a scheduled capture strobe. The bench pulses start_i exactly on slot 1's strobe cycle and checks that the strobe pattern and the fail vector stay the same as for an undisturbed run.

// File: rtl/rsp_pkg.sv
package rsp_pkg;
   // Replace a zero access time with the smallest legal value
   function automatic logic [3:0] acc_floor(input logic [3:0] a);
      return (a == 4'd0) ? 4'd1 : a;
   endfunction
endpackage

// File: rtl/rsp_seq.sv
module rsp_seq #(
   parameter int SLOTS = 4,
   parameter int TW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [TW-1:0]    acc_i,
   output logic [SLOTS-1:0] stb_o,
   output logic             busy_o,
   output logic             fin_o
);
   localparam int IW = (SLOTS > 2) ? $clog2(SLOTS) : 1;
   localparam logic [IW-1:0] LAST = IW'(SLOTS - 1);

   logic          busy_q, fin_q;
   logic [IW-1:0] idx_q;
   logic [TW-1:0] cnt_q, per_q, per_eff;
   logic          go, fire;

   assign per_eff = (acc_i == '0) ? TW'(1) : acc_i;
   assign go      = start_i && !busy_q;
   assign fire    = busy_q && (cnt_q == '0);

   assign stb_o[0] = go;
   for (genvar k = 1; k < SLOTS; k++) begin : g_stb
      assign stb_o[k] = fire && (idx_q == IW'(k));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         fin_q  <= 1'b0;
         idx_q  <= '0;
         cnt_q  <= '0;
         per_q  <= '0;
      end else begin
         fin_q <= fire && (idx_q == LAST);
         if (go) begin
            busy_q <= 1'b1;
            idx_q  <= IW'(1);
            cnt_q  <= per_eff - TW'(1);
            per_q  <= per_eff;
         end else if (fire) begin
            if (idx_q == LAST) begin
               busy_q <= 1'b0;
            end else begin
               idx_q <= idx_q + IW'(1);
               cnt_q <= per_q - TW'(1);
            end
         end else if (busy_q) begin
            cnt_q <= cnt_q - TW'(1);
         end
      end
   end

   assign busy_o = busy_q;
   assign fin_o  = fin_q;
endmodule

// File: rtl/rsp_slot.sv
module rsp_slot #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          stb_i,
   input  logic [DW-1:0] din_i,
   input  logic [DW-1:0] ref_i,
   input  logic [DW-1:0] mask_i,
   output logic          miss_o
);
   logic [DW-1:0] cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cap_q <= '0;
      else if (stb_i) cap_q <= din_i;
   end

   assign miss_o = |((cap_q ^ ref_i) & ~mask_i);
endmodule

// File: rtl/rsp_compare.sv
module rsp_compare #(
   parameter int DW    = 16,
   parameter int SLOTS = 4,
   parameter int TW    = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic [TW-1:0]       acc_time_i,
   input  logic                mask_we_i,
   input  logic [DW-1:0]       mask_d_i,
   input  logic [DW-1:0]       rd_data_i,
   input  logic [SLOTS*DW-1:0] ref_i,
   input  logic                clr_i,
   output logic [SLOTS-1:0]    cap_stb_o,
   output logic                busy_o,
   output logic                done_o,
   output logic [SLOTS-1:0]    fail_vec_o,
   output logic                sticky_o
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("rsp_compare: SLOTS must be at least 2");
   end
   if (DW < 1 || TW < 1) begin : g_bad_width
      $error("rsp_compare: DW and TW must be positive");
   end

   logic [DW-1:0]    mask_q;
   logic [SLOTS-1:0] miss, fvec_q;
   logic             fin, done_q, sticky_q;

   rsp_seq #(.SLOTS(SLOTS), .TW(TW)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_i(acc_time_i),
      .stb_o(cap_stb_o), .busy_o(busy_o), .fin_o(fin)
   );

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      rsp_slot #(.DW(DW)) u_slot (
         .clk(clk), .rst_n(rst_n), .stb_i(cap_stb_o[i]), .din_i(rd_data_i),
         .ref_i(ref_i[i*DW +: DW]), .mask_i(mask_q), .miss_o(miss[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q   <= '0;
         done_q   <= 1'b0;
         fvec_q   <= '0;
         sticky_q <= 1'b0;
      end else begin
         if (mask_we_i) mask_q <= mask_d_i;
         done_q <= fin;
         if (fin) fvec_q <= miss;
         sticky_q <= (sticky_q && !clr_i) || (fin && (|miss));
      end
   end

   assign done_o     = done_q;
   assign fail_vec_o = fvec_q;
   assign sticky_o   = sticky_q;
endmodule

// File: rtl/rsp_compare_chk.sv
module rsp_compare_chk #(
   parameter int SLOTS = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             clr_i,
   input logic [SLOTS-1:0] cap_stb_o,
   input logic             busy_o,
   input logic             done_o,
   input logic [SLOTS-1:0] fail_vec_o,
   input logic             sticky_o
);
   // R2
   stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cap_stb_o));
   // R9
   busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb_o[SLOTS-1] |=> !busy_o);
   // R9
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i));
   // R6
   done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_stb_o[SLOTS-1] |=> ##1 done_o);
   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R6
   fvec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> $stable(fail_vec_o));
   // R7
   sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && (|fail_vec_o)) |-> sticky_o);
   // R7
   sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sticky_o && !clr_i) |=> sticky_o);
   // R8
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |-> !cap_stb_o[0]);
endmodule

bind rsp_compare rsp_compare_chk #(.SLOTS(SLOTS)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .clr_i(clr_i),
   .cap_stb_o(cap_stb_o), .busy_o(busy_o), .done_o(done_o),
   .fail_vec_o(fail_vec_o), .sticky_o(sticky_o)
);

// File: tb/rsp_compare_tb.sv
module rsp_compare_tb;
   localparam int CLK_P = 10;
   localparam int DW = 16;
   localparam int NS = 4;

   typedef struct packed {
      logic [3:0]  acc;
      logic [15:0] mask;
      logic [63:0] err;
      logic        bump;
      logic [3:0]  fv;
   } vec_t;

   localparam vec_t TBL [0:6] = '{
      '{4'd1,  16'h0000, 64'h0000_0000_0000_0000, 1'b0, 4'b0000},
      '{4'd3,  16'h0000, 64'h0000_0020_0000_0000, 1'b0, 4'b0100},
      '{4'd2,  16'h00F0, 64'h0100_0000_0000_0010, 1'b0, 4'b1000},
      '{4'd15, 16'hFFFF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 4'b0000},
      '{4'd0,  16'h0000, 64'h0000_0000_0001_0000, 1'b1, 4'b0010},
      '{4'd5,  16'h8000, 64'h0000_0000_8001_8000, 1'b1, 4'b0010},
      '{4'd2,  16'h0000, 64'h0001_0002_0004_0008, 1'b0, 4'b1111}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_i = 1'b0, mask_we_i = 1'b0, clr_i = 1'b0;
   logic [3:0] acc_time_i = '0;
   logic [DW-1:0] mask_d_i = '0, rd_data_i = '0;
   logic [NS*DW-1:0] ref_i = '0;
   logic [NS-1:0] cap_stb_o, fail_vec_o;
   logic busy_o, done_o, sticky_o;

   int checks = 0, errors = 0;
   logic sticky_exp = 1'b0;
   logic [NS-1:0] fv_last = '0;

   always #(CLK_P/2) clk = ~clk;

   rsp_compare #(.DW(DW), .SLOTS(NS), .TW(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .acc_time_i(acc_time_i),
      .mask_we_i(mask_we_i), .mask_d_i(mask_d_i), .rd_data_i(rd_data_i),
      .ref_i(ref_i), .clr_i(clr_i), .cap_stb_o(cap_stb_o), .busy_o(busy_o),
      .done_o(done_o), .fail_vec_o(fail_vec_o), .sticky_o(sticky_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run(input logic [3:0] acc, input logic [15:0] mask,
                      input logic [63:0] err, input logic bump, input logic clr_done,
                      input logic [NS-1:0] fv, input int seed);
      int t;
      int last;
      int bad;
      logic [DW-1:0] base [NS];
      t = (acc == 4'd0) ? 1 : int'(acc);
      last = (NS - 1) * t;
      bad = 0;
      for (int i = 0; i < NS; i++) begin
         base[i] = DW'(16'h1000 * (seed + 1) + 16'h0111 * i);
         ref_i[i*DW +: DW] = base[i];
      end
      // R5: load the mask, then move mask_d_i without a write enable
      @(negedge clk);
      mask_we_i = 1'b1; mask_d_i = mask;
      @(negedge clk);
      mask_we_i = 1'b0; mask_d_i = ~mask;
      acc_time_i = acc;
      for (int k = 0; k <= last; k++) begin
         logic [NS-1:0] stb_exp;
         if (k > 0) @(negedge clk);
         start_i = (k == 0) || (bump && k == t);
         if (k % t == 0) rd_data_i = base[k / t] ^ err[(k / t)*DW +: DW];
         else rd_data_i = 16'hDEAD ^ DW'(k);
         stb_exp = (k % t == 0) ? NS'(1 << (k / t)) : '0;
         if (k == 4) acc_time_i = 4'd7;
         #1;
         if (cap_stb_o !== stb_exp) bad++;
         if (k > 0 && busy_o !== 1'b1) bad++;
      end
      // R2 R3 R8 R9: strobe and busy pattern over the whole run
      check(bad == 0, "R2/R3/R8/R9 strobe timing", 64'(bad), 64'd0);
      @(negedge clk);
      start_i = 1'b0;
      rd_data_i = 16'hBEEF;
      check(done_o === 1'b0 && busy_o === 1'b0, "R6/R9 idle before done",
            {62'd0, done_o, busy_o}, 64'd0);
      clr_i = clr_done;
      @(negedge clk);
      clr_i = 1'b0;
      sticky_exp = (sticky_exp && !clr_done) || (|fv);
      check(done_o === 1'b1, "R6 done pulse", 64'(done_o), 64'd1);
      // R4 R5 fail vector with masking
      check(fail_vec_o === fv, "R4/R5 fail vector", 64'(fail_vec_o), 64'(fv));
      // R7 sticky accumulation
      check(sticky_o === sticky_exp, "R7 sticky", 64'(sticky_o), 64'(sticky_exp));
      fv_last = fv;
      @(negedge clk);
      check(done_o === 1'b0 && fail_vec_o === fv, "R6 done one cycle, vector held",
            {59'd0, done_o, fail_vec_o}, {60'd0, fv});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      // R1: reset state
      check(cap_stb_o === '0 && busy_o === 1'b0 && done_o === 1'b0 &&
            fail_vec_o === '0 && sticky_o === 1'b0, "R1 reset outputs",
            {55'd0, cap_stb_o, busy_o, done_o, fail_vec_o, sticky_o}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int v = 0; v < 7; v++) begin
         run(TBL[v].acc, TBL[v].mask, TBL[v].err, TBL[v].bump, 1'b0, TBL[v].fv, v);
      end

      // R7: clear while idle drops the flag; R6: vector stays held
      @(negedge clk);
      clr_i = 1'b1;
      @(negedge clk);
      clr_i = 1'b0;
      sticky_exp = 1'b0;
      check(sticky_o === 1'b0, "R7 clear alone", 64'(sticky_o), 64'd0);
      check(fail_vec_o === fv_last, "R6 vector held across clear",
            64'(fail_vec_o), 64'(fv_last));

      // R7: clear and failing done on the same edge, the set wins
      run(4'd1, 16'h0000, 64'h0000_0000_0000_0001, 1'b0, 1'b1, 4'b0001, 9);
      // R7: clear and passing done on the same edge, the flag ends low
      run(4'd2, 16'h0000, 64'h0, 1'b0, 1'b1, 4'b0000, 10);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule